// File: doc/BRIEF.md
# Bit-Split Multi-Keyword Matcher

This block scans a payload byte stream for up to sixteen fixed keywords in parallel. Rather than one large automaton that branches 256 ways on every byte, it cuts each byte into one-bit slices and hands slice i to its own small automaton. Each automaton holds a state table in which every state has two successor pointers, one per input bit value, and a sixteen-bit vector of the keywords it may have just seen. The eight partial vectors are ANDed, so a keyword is reported only when all slices agree on it. The tables come from an offline compiler that has already folded the failure edges into the stored pointers. As a result, a keyword can begin at any byte, and each automaton takes exactly one step per byte.

The stream input follows valid/ready rules. The block never back-pressures, so `in_ready` stays high and a byte transfers on every clock in which `in_valid` is high. The match output is a registered valid-qualified vector with no ready, because the block issues at most one result per accepted byte. Software loads the tables through a plain write port. This is done between packets, in cycles with no byte on the stream.

The slice width is a parameter. With two bits per slice there are four automata, each with four pointers per state.

Top module: `bitsplit_matcher`

## Requirements
- R1: `in_ready` is high in every cycle after reset, and one byte is accepted on each clock where `in_valid` is high.
- R2: Bit i of `in_byte` (bit 0 = LSB) is the only input to automaton i.
- R3: A table word is 34 bits. Bits [33:18] hold the keyword vector of the state, bits [17:9] hold the successor for input bit 1, and bits [8:0] hold the successor for input bit 0.
- R4: Each accepted byte moves every automaton through exactly one transition. Cycles without an accepted byte leave all automaton states unchanged.
- R5: On a byte with `in_sop` high, every automaton takes its transition from state 0, whatever state it was in before.
- R6: `match_vec` is the bitwise AND of the keyword vectors of the states the eight automata entered on that byte.
- R7: `match_valid` and `match_vec` are registered and appear on the clock after the byte is accepted. After a cycle with no accepted byte, `match_valid` is 0 and `match_vec` is 0.
- R8: A write with `wr_en` high is applied to entry `wr_addr` of the table of automaton `wr_mach` only when `in_valid` is low. A write presented while `in_valid` is high is ignored.
- R9: After reset, all automata are in state 0, and `match_valid` and `match_vec` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Payload byte present |
| in_ready | output | 1 | Block accepts a byte (always high) |
| in_sop | input | 1 | Byte is the first of a packet |
| in_byte | input | 8 | Payload byte |
| wr_en | input | 1 | Table write strobe |
| wr_mach | input | 3 | Automaton whose table is written |
| wr_addr | input | 9 | State entry written |
| wr_data | input | 34 | Table word, layout as in R3 |
| match_valid | output | 1 | Result for the previous accepted byte |
| match_vec | output | 16 | Keywords confirmed by all automata |

## Verification
A wrong automaton state does not show at once. It shows only when that automaton's keyword vector for the state it entered differs from the correct one in a bit that the other seven automata also hold. A wrong successor can therefore stay hidden for several bytes. It then surfaces as a missing or spurious bit in `match_vec` one clock after the byte that exposes it. The bench uses densely populated random vectors, so the AND leaves bits set often, and it compares every cycle against an independent model. This catches a divergence within a few bytes. It also catches any write that leaked through while a byte was on the stream, as soon as the corrupted entry is next visited.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/bsm_state_table.sv
module bsm_state_table #(
  parameter int WORD_W = 34,
  parameter int PTR_W  = 9,
  parameter int STATES = 384
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  ra_addr,
  output logic [WORD_W-1:0] ra_data,
  input  logic [PTR_W-1:0]  rb_addr,
  output logic [WORD_W-1:0] rb_data
);
  localparam int AW = $clog2(STATES);

  logic [WORD_W-1:0] mem [STATES];

  // Table changes only between bytes; out-of-range entries are dropped.
  always_ff @(posedge clk) begin
    if (wr_en && !busy && (int'(wr_addr) < STATES))
      mem[wr_addr[AW-1:0]] <= wr_data;
  end

  assign ra_data = (int'(ra_addr) < STATES) ? mem[ra_addr[AW-1:0]] : '0;
  assign rb_data = (int'(rb_addr) < STATES) ? mem[rb_addr[AW-1:0]] : '0;
endmodule

// File: rtl/bsm_slice.sv
module bsm_slice #(
  parameter int SLICE_W = 1,
  parameter int PTR_W   = 9,
  parameter int KW      = 16,
  parameter int STATES  = 384
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 sop,
  input  logic [SLICE_W-1:0]   sym,
  input  logic                 wr_sel,
  input  logic                 busy,
  input  logic [PTR_W-1:0]     wr_addr,
  input  logic [KW+(1<<SLICE_W)*PTR_W-1:0] wr_data,
  output logic [KW-1:0]        part_vec
);
  localparam int FANOUT = 1 << SLICE_W;
  localparam int WORD_W = KW + FANOUT * PTR_W;

  logic [PTR_W-1:0]  state_q;
  logic [PTR_W-1:0]  base;
  logic [PTR_W-1:0]  nxt;
  logic [WORD_W-1:0] word_cur;
  logic [WORD_W-1:0] word_nxt;

  bsm_state_table #(.WORD_W(WORD_W), .PTR_W(PTR_W), .STATES(STATES)) u_table (
    .clk     (clk),
    .wr_en   (wr_sel),
    .busy    (busy),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ra_addr (base),
    .ra_data (word_cur),
    .rb_addr (nxt),
    .rb_data (word_nxt)
  );

  always_comb begin
    base     = sop ? '0 : state_q;
    nxt      = word_cur[int'(sym)*PTR_W +: PTR_W];
    part_vec = word_nxt[WORD_W-1 -: KW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= '0;
    else if (step) state_q <= nxt;
  end

  // R4: an automaton never moves without an accepted byte
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state_q));
endmodule

// File: rtl/bitsplit_matcher.sv
module bitsplit_matcher #(
  parameter int KW      = 16,
  parameter int PTR_W   = 9,
  parameter int STATES  = 384,
  parameter int SLICE_W = 1,
  localparam int N_MACH = bsm_pkg::BYTE_W / SLICE_W,
  localparam int MID_W  = (N_MACH > 1) ? $clog2(N_MACH) : 1,
  localparam int WORD_W = KW + (1 << SLICE_W) * PTR_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_sop,
  input  logic [bsm_pkg::BYTE_W-1:0] in_byte,
  input  logic                      wr_en,
  input  logic [MID_W-1:0]          wr_mach,
  input  logic [PTR_W-1:0]          wr_addr,
  input  logic [WORD_W-1:0]         wr_data,
  output logic                      match_valid,
  output logic [KW-1:0]             match_vec
);
  logic [KW-1:0] parts [N_MACH];
  logic [KW-1:0] agreed;

  assign in_ready = 1'b1;

  for (genvar g = 0; g < N_MACH; g++) begin : g_slice
    bsm_slice #(.SLICE_W(SLICE_W), .PTR_W(PTR_W), .KW(KW), .STATES(STATES)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (in_valid),
      .sop      (in_sop),
      .sym      (in_byte[g*SLICE_W +: SLICE_W]),
      .wr_sel   (wr_en && (wr_mach == MID_W'(g))),
      .busy     (in_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .part_vec (parts[g])
    );
  end

  always_comb begin
    agreed = '1;
    for (int m = 0; m < N_MACH; m++) agreed &= parts[m];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_valid <= 1'b0;
      match_vec   <= '0;
    end else begin
      match_valid <= in_valid;
      match_vec   <= in_valid ? agreed : '0;
    end
  end

  // R7: result follows each accepted byte by one clock
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> match_valid);
  // R7: idle cycle gives an empty, invalid result
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!match_valid && match_vec == '0));
  // R6: a confirmed keyword was flagged by automaton 0
  assert_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((match_vec & ~$past(parts[0])) == '0));
endmodule

// File: tb/bitsplit_matcher_tb.sv
module bitsplit_matcher_tb;
  localparam int CLK_P = 10;
  localparam int NS    = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sop = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_mach = '0;
  logic [8:0]  wr_addr = '0;
  logic [33:0] wr_data = '0;
  logic        match_valid;
  logic [15:0] match_vec;

  int checks = 0;
  int fails  = 0;

  logic [33:0] rm [8][384];
  int          st [8];
  logic        exp_valid = 1'b0;
  logic [15:0] exp_vec = '0;

  always #(CLK_P/2) clk = ~clk;

  bitsplit_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_byte(in_byte), .wr_en(wr_en), .wr_mach(wr_mach),
    .wr_addr(wr_addr), .wr_data(wr_data), .match_valid(match_valid),
    .match_vec(match_vec)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [33:0] rand_word();
    logic [15:0] mv;
    mv = 16'($urandom | $urandom);
    return {mv, 9'($urandom_range(0, NS-1)), 9'($urandom_range(0, NS-1))};
  endfunction

  // One clock: check previous result, then drive and update the model.
  task automatic cyc(input bit v, input bit sop, input logic [7:0] b,
                     input bit we, input int wm, input int wa,
                     input logic [33:0] wd, input string tag);
    logic [15:0] acc;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", 32'(in_ready), 32'd1);
    chk(match_valid == exp_valid, "R7", 32'(match_valid), 32'(exp_valid));
    chk(match_vec == exp_vec, tag, 32'(match_vec), 32'(exp_vec));
    in_valid = v; in_sop = sop; in_byte = b;
    wr_en = we; wr_mach = 3'(wm); wr_addr = 9'(wa); wr_data = wd;
    if (v) begin
      acc = '1;
      for (int m = 0; m < 8; m++) begin
        int from;
        logic [33:0] w;
        from = sop ? 0 : st[m];
        w = rm[m][from];
        st[m] = b[m] ? int'(w[17:9]) : int'(w[8:0]);
        acc &= rm[m][st[m]][33:18];
      end
      exp_valid = 1'b1;
      exp_vec = acc;
    end else begin
      exp_valid = 1'b0;
      exp_vec = '0;
      if (we) rm[wm][wa] = wd;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int m = 0; m < 8; m++) begin
      st[m] = 0;
      for (int s = 0; s < 384; s++) rm[m][s] = '0;
    end
    // R9: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(match_valid == 1'b0, "R9", 32'(match_valid), 32'd0);
      chk(match_vec == '0, "R9", 32'(match_vec), 32'd0);
    end
    rst_n = 1'b1;
    // R3: load tables in the documented word layout while idle
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < NS; s++)
        cyc(0, 0, 8'h00, 1, m, s, rand_word(), "R3");
    // R9: first byte without start-of-packet begins from state 0
    for (int i = 0; i < 20; i++)
      cyc(1, 0, 8'($urandom), 0, 0, 0, '0, "R9");
    // R2: walking single bits steer individual automata
    for (int i = 0; i < 64; i++)
      cyc(1, (i % 16) == 0, 8'(1 << (i % 8)) ^ ((i / 8) % 2 == 1 ? 8'hFF : 8'h00), 0, 0, 0, '0, "R2");
    // R5: frequent packet starts
    for (int i = 0; i < 120; i++)
      cyc(1, (i % 3) == 0, 8'($urandom), 0, 0, 0, '0, "R5");
    // R4: idle gaps must not move any automaton
    for (int i = 0; i < 200; i++) begin
      bit v;
      v = ($urandom % 3) != 0;
      cyc(v, 0, 8'($urandom), 0, 0, 0, '0, "R4");
    end
    // R8: writes presented while bytes flow are ignored
    for (int i = 0; i < 200; i++)
      cyc(1, (i % 40) == 0, 8'($urandom), 1, int'($urandom % 8), int'($urandom % NS),
          rand_word(), "R8");
    // R6: mixed traffic with live table updates between bytes
    for (int i = 0; i < 800; i++) begin
      bit v;
      v = ($urandom % 4) != 0;
      cyc(v, ($urandom % 16) == 0, 8'($urandom), ($urandom % 4) == 0,
          int'($urandom % 8), int'($urandom % NS), rand_word(), "R6");
    end
    cyc(0, 0, 8'h00, 0, 0, 0, '0, "R7");
    cyc(0, 0, 8'h00, 0, 0, 0, '0, "R7");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule